// File: doc/BRIEF.md
# Exact-Count I/O Bus Cycle Splitter

This block sits between a processor's I/O-space access path and a 16-bit I/O bus. The processor side presents one access of 1, 2 or 3 bytes at any byte address, with write data right-aligned. The block turns that access into the smallest correct series of bus cycles. Reads on this bus can have side effects, and a byte write is not the same as a word read-modify-write. For that reason the block never issues a cycle it does not need, never reads as part of a write, and never widens a byte write to a word.

The bus side runs one cycle at a time. Each cycle drives an address, a byte/word select, a direction and, for writes, data, and it is held until an acknowledge comes back. Read results are put together into a 32-bit value. A single-word read lands in the low half, or in the high half when address bit 1 is set. A two-word read returns the second word above the first. A pulse on `req_done` reports the end of a transfer. An access length the block does not support pulses `req_err` and starts no bus activity.

Top module: `iosplit_top`

## Requirements
- R1: A write of length 1 at any byte offset produces exactly one byte cycle (`bus_byte`=1) at the request address, carrying write data bits [7:0] on `bus_wdata[7:0]` with `bus_wdata[15:8]`=0.
- R2: A write of length 2 at an even address produces exactly one word cycle (`bus_byte`=0) at the request address with data bits [15:0]. At an odd address it produces two byte cycles: the first at the address with bits [7:0], then one at address+1 with bits [15:8].
- R3: A write of length 3 at an even address produces a word cycle at the address with bits [15:0], followed by a byte cycle at address+2 with bits [23:16].
- R4: A write of length 3 at an odd address produces a byte cycle at the address with bits [7:0], followed by a word cycle at address+1 with bits [23:8].
- R5: A read where length plus address bit 0 is at most 2 produces exactly one word cycle at the request address. The 16-bit result appears in `req_rdata[15:0]` with the upper half zero, or in `req_rdata[31:16]` with the lower half zero when address bit 1 is set.
- R6: Any other read produces exactly two word cycles, at the address and then at address+2, and returns {second word, first word}.
- R7: Every read cycle is a word cycle. Every cycle of a write request has `bus_write`=1, so no read ever takes place during a write.
- R8: Each bus cycle holds its address, select and data until the cycle in which `bus_ack` is sampled high. The next cycle is issued only after that. The transfer completes in n*(W+2) clocks after acceptance, where n is the cycle count and W is the number of wait clocks before the acknowledge.
- R9: `req_done` is high for exactly one clock, in the clock after the last acknowledge is sampled, and `req_rdata` is valid at that time.
- R10: A request with length 0 or greater than 3 raises `req_err` for one clock in the clock after acceptance, issues no bus cycle, and does not raise `req_done`.
- R11: A request presented while a transfer is in progress is ignored and adds no bus cycle.
- R12: After reset, `bus_req`, `req_done` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_len | input | 3 | Length in bytes (1..3 valid) |
| req_wdata | input | 24 | Right-aligned write data |
| req_done | output | 1 | One-clock completion pulse |
| req_err | output | 1 | One-clock unsupported-length pulse |
| req_rdata | output | 32 | Assembled read result |
| bus_req | output | 1 | Bus cycle active |
| bus_addr | output | AW | Bus cycle byte address |
| bus_byte | output | 1 | 1 = byte cycle, 0 = word cycle |
| bus_write | output | 1 | Bus cycle direction |
| bus_wdata | output | 16 | Bus write data (byte in [7:0]) |
| bus_rdata | input | 16 | Bus read data, taken with ack |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The hardest situations to reach are the two-cycle splits in which the second cycle's address and width differ from the first. Examples are the odd triword write, whose byte cycle is followed by a word cycle at address+1, and the odd word read, which needs a second word cycle. These must be checked while the acknowledge arrives after different numbers of wait clocks. The bench sweeps every length from 0 to 4, every byte offset and both directions at ack delays of 0, 1 and 2 clocks. The bus model stamps each read word with a running read count, so an extra or reordered read shows up in the assembled result. While each transfer is in progress, the bench also drives a conflicting request, and the logged cycle count shows whether that request was taken.

// File: rtl/iosplit_pkg.sv
package iosplit_pkg;
  localparam int BUS_W  = 16;
  localparam int DATA_W = 24;
  localparam int RES_W  = 2 * BUS_W;
  localparam int LEN_W  = 3;
  localparam int OFF_W  = 2;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    logic             is_byte;
    logic [BUS_W-1:0] data;
  } cyc_t;

  typedef struct packed {
    logic bad;
    logic two;
    logic rd_hi;
    cyc_t c0;
    cyc_t c1;
  } plan_t;
endpackage

// File: rtl/iosplit_plan.sv
module iosplit_plan
  import iosplit_pkg::*;
(
  input  logic              wr,
  input  logic [OFF_W-1:0]  alo,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wd,
  output plan_t             pl
);
  logic [LEN_W-1:0] span;

  assign span = len + {{(LEN_W-1){1'b0}}, alo[0]};

  always_comb begin
    pl = '0;
    if (len == '0 || len > LEN_W'(3)) begin
      pl.bad = 1'b1;
    end else if (!wr) begin
      pl.c0.off     = 2'd0;
      pl.c0.is_byte = 1'b0;
      if (span <= LEN_W'(2)) begin
        pl.rd_hi = alo[1];
      end else begin
        pl.two        = 1'b1;
        pl.c1.off     = 2'd2;
        pl.c1.is_byte = 1'b0;
      end
    end else begin
      case (len)
        LEN_W'(1): begin
          pl.c0.is_byte = 1'b1;
          pl.c0.data    = {8'h00, wd[7:0]};
        end
        LEN_W'(2): begin
          if (!alo[0]) begin
            pl.c0.data = wd[15:0];
          end else begin
            pl.two        = 1'b1;
            pl.c0.is_byte = 1'b1;
            pl.c0.data    = {8'h00, wd[7:0]};
            pl.c1.off     = 2'd1;
            pl.c1.is_byte = 1'b1;
            pl.c1.data    = {8'h00, wd[15:8]};
          end
        end
        default: begin
          pl.two = 1'b1;
          if (!alo[0]) begin
            pl.c0.data    = wd[15:0];
            pl.c1.off     = 2'd2;
            pl.c1.is_byte = 1'b1;
            pl.c1.data    = {8'h00, wd[23:16]};
          end else begin
            pl.c0.is_byte = 1'b1;
            pl.c0.data    = {8'h00, wd[7:0]};
            pl.c1.off     = 2'd1;
            pl.c1.data    = wd[23:8];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/iosplit_seq.sv
module iosplit_seq
  import iosplit_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  plan_t            pl,
  input  logic             bus_ack,
  output logic             bus_req,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_byte,
  output logic             bus_write,
  output logic [BUS_W-1:0] bus_wdata,
  output logic             done,
  output logic             err,
  output logic             fire,
  output logic             second,
  output logic             two_r,
  output logic             hi_r
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_t;
  st_t           st;
  cyc_t          c1_r;
  logic [AW-1:0] base_r;

  assign fire = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      bus_byte  <= 1'b0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      second    <= 1'b0;
      two_r     <= 1'b0;
      hi_r      <= 1'b0;
      c1_r      <= '0;
      base_r    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (pl.bad) begin
              err <= 1'b1;
            end else begin
              st        <= ST_BUSY;
              bus_req   <= 1'b1;
              bus_addr  <= req_addr + AW'(pl.c0.off);
              bus_byte  <= pl.c0.is_byte;
              bus_write <= req_write;
              bus_wdata <= pl.c0.data;
              second    <= 1'b0;
              two_r     <= pl.two;
              hi_r      <= pl.rd_hi;
              c1_r      <= pl.c1;
              base_r    <= req_addr;
            end
          end
        end
        default: begin
          if (bus_ack) begin
            if (!second && two_r) begin
              second    <= 1'b1;
              bus_addr  <= base_r + AW'(c1_r.off);
              bus_byte  <= c1_r.is_byte;
              bus_wdata <= c1_r.data;
            end else begin
              bus_req <= 1'b0;
              done    <= 1'b1;
              st      <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_byte) && $stable(bus_wdata) && $stable(bus_write)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(bus_ack) && $past(bus_req)); // R9
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    err |-> !bus_req && !done); // R10
  AST_READ_WORDS: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_write |-> !bus_byte); // R7
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_write && bus_byte |-> bus_wdata[15:8] == 8'h00); // R1
endmodule

// File: rtl/iosplit_rdasm.sv
module iosplit_rdasm
  import iosplit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             rd,
  input  logic             second,
  input  logic             two,
  input  logic             hi,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [RES_W-1:0] rdata
);
  logic [BUS_W-1:0] lo_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_w  <= '0;
      rdata <= '0;
    end else if (fire && rd) begin
      if (second) begin
        rdata <= {bus_rdata, lo_w};
      end else if (two) begin
        lo_w <= bus_rdata;
      end else if (hi) begin
        rdata <= {bus_rdata, {BUS_W{1'b0}}};
      end else begin
        rdata <= {{BUS_W{1'b0}}, bus_rdata};
      end
    end
  end

  AST_SINGLE_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    fire && rd && !two && !hi |=> rdata[RES_W-1:BUS_W] == '0); // R5
  AST_SINGLE_HIGH_ONLY: assert property (@(posedge clk) disable iff (rst)
    fire && rd && !two && hi |=> rdata[BUS_W-1:0] == '0); // R5
endmodule

// File: rtl/iosplit_top.sv
module iosplit_top
  import iosplit_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [2:0]        req_len,
  input  logic [23:0]       req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [31:0]       req_rdata,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_byte,
  output logic              bus_write,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_ack
);
  plan_t pl;
  logic  fire, second, two_r, hi_r;

  iosplit_plan u_plan (
    .wr  (req_write),
    .alo (req_addr[1:0]),
    .len (req_len),
    .wd  (req_wdata),
    .pl  (pl)
  );

  iosplit_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .pl        (pl),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_byte  (bus_byte),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .done      (req_done),
    .err       (req_err),
    .fire      (fire),
    .second    (second),
    .two_r     (two_r),
    .hi_r      (hi_r)
  );

  iosplit_rdasm u_rdasm (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .rd        (!bus_write),
    .second    (second),
    .two       (two_r),
    .hi        (hi_r),
    .bus_rdata (bus_rdata),
    .rdata     (req_rdata)
  );
endmodule

// File: tb/tb_iosplit_top.sv
`timescale 1ns/1ps
module tb_iosplit_top;
  localparam int AW = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_len = '0;
  logic [23:0] req_wdata = '0;
  logic req_done, req_err, bus_req, bus_byte, bus_write, bus_ack;
  logic [31:0] req_rdata;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int checks = 0, fails = 0;
  int cyc = 0, dly = 0, wcnt = 0, rcnt = 0, ltot = 0, last_ack = 0;
  logic ack_r = 1'b0;
  logic [15:0] rd_r = '0;
  logic [AW-1:0] lg_addr [64];
  logic lg_byte [64];
  logic lg_wr [64];
  logic [15:0] lg_data [64];

  always #5 clk = ~clk;

  iosplit_top #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_done(req_done), .req_err(req_err), .req_rdata(req_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_byte(bus_byte),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  assign bus_ack = ack_r;
  assign bus_rdata = rd_r;

  // bus model: ack after dly wait clocks, reads return {read count, addr low byte}
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      ack_r <= 1'b0;
      wcnt  <= 0;
    end else if (ack_r) begin
      ack_r    <= 1'b0;
      wcnt     <= 0;
      last_ack <= cyc;
    end else if (bus_req) begin
      if (wcnt >= dly) begin
        ack_r <= 1'b1;
        lg_addr[ltot % 64] <= bus_addr;
        lg_byte[ltot % 64] <= bus_byte;
        lg_wr[ltot % 64]   <= bus_write;
        lg_data[ltot % 64] <= bus_wdata;
        ltot <= ltot + 1;
        if (!bus_write) begin
          rd_r <= {rcnt[7:0], bus_addr[7:0]};
          rcnt <= rcnt + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [2:0] l, input logic [23:0] d);
    int n = 0, t0, r0, c0, to = 0;
    bit bad;
    string tag;
    logic [AW-1:0] ea [2];
    logic eb [2];
    logic [15:0] ed [2];
    logic [31:0] er;
    bad = (l == 0) || (l > 3);
    er = '0;
    if (!bad && w) begin
      tag = (l == 1) ? "R1" : (l == 2) ? "R2" : a[0] ? "R4" : "R3";
      if (l == 1) begin n = 1; ea[0] = a; eb[0] = 1; ed[0] = {8'h0, d[7:0]}; end
      else if (l == 2 && !a[0]) begin n = 1; ea[0] = a; eb[0] = 0; ed[0] = d[15:0]; end
      else if (l == 2) begin n = 2; ea[0] = a; eb[0] = 1; ed[0] = {8'h0, d[7:0]};
        ea[1] = a + 1; eb[1] = 1; ed[1] = {8'h0, d[15:8]}; end
      else if (!a[0]) begin n = 2; ea[0] = a; eb[0] = 0; ed[0] = d[15:0];
        ea[1] = a + 2; eb[1] = 1; ed[1] = {8'h0, d[23:16]}; end
      else begin n = 2; ea[0] = a; eb[0] = 1; ed[0] = {8'h0, d[7:0]};
        ea[1] = a + 1; eb[1] = 0; ed[1] = d[23:8]; end
    end else if (!bad) begin
      r0 = rcnt;
      ea[0] = a; eb[0] = 0; ed[0] = 'x;
      if ({1'b0, l} + a[0] <= 2) begin
        tag = "R5"; n = 1;
        er = a[1] ? {r0[7:0], a[7:0], 16'h0} : {16'h0, r0[7:0], a[7:0]};
      end else begin
        tag = "R6"; n = 2;
        ea[1] = a + 2; eb[1] = 0; ed[1] = 'x;
        er = {r0[7:0] + 8'd1, ea[1][7:0], r0[7:0], a[7:0]};
      end
    end else tag = "R10";
    t0 = ltot;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_len = l; req_wdata = d;
    c0 = cyc;
    @(negedge clk);
    req_valid = 0;
    while (!req_done && !req_err && to < 100) begin
      if (to == 0 && !bad) begin // R11: conflicting request mid-transfer
        req_valid = 1; req_write = ~w; req_addr = a ^ 16'h0101; req_len = 3'd2;
      end
      @(negedge clk);
      req_valid = 0;
      to++;
    end
    if (bad) begin
      chk(req_err && !req_done, "R10 err pulse", {req_err, req_done}, 2'b10);
      chk(cyc - c0 == 1, "R10 err timing", cyc - c0, 1);
      chk(ltot == t0, "R10 no bus cycle", ltot - t0, 0);
      @(negedge clk);
      chk(!req_err, "R10 err one clock", req_err, 0);
    end else begin
      chk(req_done, {tag, " done seen"}, req_done, 1);
      chk(cyc - c0 == 1 + n * (dly + 2), "R8 transfer latency", cyc - c0, 1 + n * (dly + 2));
      chk(cyc == last_ack + 1, "R9 done after last ack", cyc, last_ack + 1);
      chk(ltot - t0 == n, {tag, " R11 cycle count"}, ltot - t0, n);
      for (int k = 0; k < n && k < ltot - t0; k++) begin
        chk(lg_addr[(t0 + k) % 64] == ea[k], {tag, " addr"}, lg_addr[(t0 + k) % 64], ea[k]);
        chk(lg_byte[(t0 + k) % 64] == eb[k], {tag, " R7 width"}, lg_byte[(t0 + k) % 64], eb[k]);
        chk(lg_wr[(t0 + k) % 64] == w, {tag, " R7 direction"}, lg_wr[(t0 + k) % 64], w);
        if (w) chk(lg_data[(t0 + k) % 64] == ed[k], {tag, " data"}, lg_data[(t0 + k) % 64], ed[k]);
      end
      if (!w) chk(req_rdata == er, {tag, " R9 result"}, req_rdata, er);
      @(negedge clk);
      chk(!req_done, "R9 done one clock", req_done, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!bus_req && !req_done && !req_err, "R12 reset state", {bus_req, req_done, req_err}, 0);
    for (int dd = 0; dd < 3; dd++) begin
      dly = dd;
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 5; l++)
          for (int o = 0; o < 4; o++)
            do_op(w[0], AW'(16'h1230 + 16'h0404 * dd + 16'h0010 * l + o), l[2:0],
                  24'h5A3C00 ^ {8'(dd * 37), 8'(l * 19 + o), 8'(o * 53 + w + 1)});
    end
    do_op(1'b1, 16'h2001, 3'd7, 24'hABCDEF); // R10 length 7
    do_op(1'b0, 16'h2003, 3'd6, 24'h0);      // R10 length 6
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule